// File: doc/BRIEF.md
# Single-Slave Memory-Write Transaction Sequencer

This block is a bus-master controller that runs one complete memory-write transaction on a one-wire style bus with a single slave attached. It does not drive the wire itself. Every bus action goes to an external bit/byte engine through a request/acknowledge port that carries an operation code and a data byte. The engine performs a line reset (and reports whether a slave answered), writes a byte, or reads a byte. Bit order on the wire and all timing belong to that engine.

The transaction proceeds in a fixed order. It opens with a line reset and checks for presence. It then writes the address-skip command and the memory-write command, followed by the 16-bit target address, low byte first. After that come the data bytes, taken one at a time from a valid/ready input stream. After each data byte the sequencer reads two check bytes and one echo byte. It packs these, together with the address the byte landed on, into a read-back record that leaves on a valid/ready output stream. The address is sent only once, and the slave increments it on its own for each following byte. A closing reset with a presence check ends the transaction.

Stream rules: the sequencer raises `din_ready` only while it waits for the next data byte, and a byte is taken on a cycle where `din_valid` and `din_ready` are both high. A record on `rb_data` is offered with `rb_valid`. Valid and data stay unchanged until a cycle with `rb_ready` high. While either stream waits, no bus operation is requested, so a slow producer or consumer only stretches the transaction.

Top module: `owseq_write_txn`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `err_nopres`, `eng_req`, `din_ready` and `rb_valid` are all low.
- R2: A transaction requests these operations in this order: a reset (op 0); writes (op 1) of CCh, 55h, the address low byte and the address high byte; then, for each data byte, a write of that byte followed by three reads (op 2); and finally a closing reset.
- R3: The address goes out once. The record for the i-th data byte (from 0) carries address start+i modulo 2^16.
- R4: A record is packed as {addr[15:0], crc[15:0], echo[7:0], bad}, with bit 0 = bad. The crc field is {second read, first read}, and echo is the third read.
- R5: When the echo byte differs from the byte written, that record has bad=1 and `error` is set. All remaining bytes are still written and reported.
- R6: When the opening reset reports no presence, the transaction stops after that single operation. No data byte is consumed and no record is produced. `error` and `err_nopres` are set and `done` pulses.
- R7: When the closing reset reports no presence, `error` and `err_nopres` are set, and `done` still pulses after all records.
- R8: With a byte count of zero, the address high byte is followed directly by the closing reset. No data is consumed.
- R9: A `start` pulse while `busy` is high is ignored and does not alter the running sequence.
- R10: A data byte is consumed only on a cycle with `din_valid` and `din_ready` both high. `eng_req` is low whenever `din_ready` is high.
- R11: `rb_valid` and `rb_data` stay stable until `rb_ready`. `eng_req` is low while `rb_valid` is high.
- R12: `done` is a one-cycle pulse. `error` and `err_nopres` hold until the next accepted `start` clears them, and `err_nopres` implies `error`.
- R13: `eng_req` stays high with `eng_op` and `eng_wdata` unchanged until a cycle with `eng_ack`. Presence (for op 0) and read data (for op 2) are sampled in the ack cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (accepted when idle) |
| start_addr | input | 16 | Target address of the first data byte |
| byte_count | input | CNT_W | Number of data bytes to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| error | output | 1 | Presence failure or echo mismatch seen |
| err_nopres | output | 1 | A reset got no presence answer |
| din_valid | input | 1 | Data byte available |
| din_ready | output | 1 | Sequencer takes a data byte |
| din_data | input | 8 | Data byte |
| rb_valid | output | 1 | Read-back record available |
| rb_ready | input | 1 | Consumer takes the record |
| rb_data | output | 41 | Read-back record |
| eng_req | output | 1 | Engine operation request |
| eng_op | output | 2 | 0 reset, 1 write, 2 read |
| eng_wdata | output | 8 | Byte to write |
| eng_ack | input | 1 | Engine operation complete |
| eng_rdata | input | 8 | Byte read, valid with ack |
| eng_presence | input | 1 | Slave answered reset, valid with ack |

## Verification
A wrong step in the controller shows up at the engine port no later than its next request, as an out-of-order operation code or write byte in the logged operation stream. A corrupted address cursor first becomes visible in the address field of the next read-back record. A lost mismatch or presence flag shows up as a wrong `error` or `err_nopres` level in the cycle `done` pulses. A stream-handshake fault shows up as a missing, repeated or altered record, or as data bytes consumed out of turn, within that transfer.

// File: rtl/owseq_pkg.sv
package owseq_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;
  localparam int REC_W  = ADDR_W + CRC_W + BYTE_W + 1;

  typedef enum logic [1:0] {
    ENG_RESET = 2'd0,
    ENG_WRITE = 2'd1,
    ENG_READ  = 2'd2
  } eng_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_OPEN,
    ST_SKIP,
    ST_CMD,
    ST_ADR_LO,
    ST_ADR_HI,
    ST_GET_DATA,
    ST_PUT_DATA,
    ST_CRC_LO,
    ST_CRC_HI,
    ST_ECHO,
    ST_PUSH,
    ST_RST_CLOSE,
    ST_FIN
  } step_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [CRC_W-1:0]  crc;
    logic [BYTE_W-1:0] echo;
    logic              bad;
  } rb_rec_t;
endpackage

// File: rtl/owseq_ctrl.sv
module owseq_ctrl
  import owseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  eng_ack,
  input  logic  eng_presence,
  input  logic  din_valid,
  input  logic  rb_ready,
  input  logic  cnt_zero,
  input  logic  cnt_last,
  input  logic  echo_bad,
  output step_e step,
  output logic  accept,
  output logic  take_data,
  output logic  advance,
  output logic  busy,
  output logic  done,
  output logic  din_ready,
  output logic  rb_valid,
  output logic  error,
  output logic  err_nopres
);
  step_e st_q, st_d;
  logic  err_q, nopres_q;
  logic  rst_step, pres_fail, echo_fail;

  assign step      = st_q;
  assign accept    = (st_q == ST_IDLE) && start;
  assign din_ready = (st_q == ST_GET_DATA);
  assign rb_valid  = (st_q == ST_PUSH);
  assign take_data = din_ready && din_valid;
  assign advance   = rb_valid && rb_ready;
  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_FIN);

  assign rst_step  = (st_q == ST_RST_OPEN) || (st_q == ST_RST_CLOSE);
  assign pres_fail = rst_step && eng_ack && !eng_presence;
  assign echo_fail = (st_q == ST_ECHO) && eng_ack && echo_bad;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:      if (start) st_d = ST_RST_OPEN;
      ST_RST_OPEN:  if (eng_ack) st_d = eng_presence ? ST_SKIP : ST_FIN;
      ST_SKIP:      if (eng_ack) st_d = ST_CMD;
      ST_CMD:       if (eng_ack) st_d = ST_ADR_LO;
      ST_ADR_LO:    if (eng_ack) st_d = ST_ADR_HI;
      ST_ADR_HI:    if (eng_ack) st_d = cnt_zero ? ST_RST_CLOSE : ST_GET_DATA;
      ST_GET_DATA:  if (din_valid) st_d = ST_PUT_DATA;
      ST_PUT_DATA:  if (eng_ack) st_d = ST_CRC_LO;
      ST_CRC_LO:    if (eng_ack) st_d = ST_CRC_HI;
      ST_CRC_HI:    if (eng_ack) st_d = ST_ECHO;
      ST_ECHO:      if (eng_ack) st_d = ST_PUSH;
      ST_PUSH:      if (rb_ready) st_d = cnt_last ? ST_RST_CLOSE : ST_GET_DATA;
      ST_RST_CLOSE: if (eng_ack) st_d = ST_FIN;
      ST_FIN:       st_d = ST_IDLE;
      default:      st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      err_q    <= 1'b0;
      nopres_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        err_q    <= 1'b0;
        nopres_q <= 1'b0;
      end else begin
        if (pres_fail) begin
          err_q    <= 1'b1;
          nopres_q <= 1'b1;
        end
        if (echo_fail) err_q <= 1'b1;
      end
    end
  end

  assign error      = err_q;
  assign err_nopres = nopres_q;
endmodule

// File: rtl/owseq_cursor.sv
module owseq_cursor
  import owseq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [CNT_W-1:0]  load_count,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output logic              zero,
  output logic              last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (load) begin
      addr_q <= load_addr;
      left_q <= load_count;
    end else if (advance) begin
      addr_q <= addr_q + ADDR_W'(1);
      left_q <= left_q - ONE;
    end
  end

  assign addr = addr_q;
  assign zero = (left_q == '0);
  assign last = (left_q == ONE);
endmodule

// File: rtl/owseq_op_sel.sv
module owseq_op_sel
  import owseq_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SKIP_CODE  = 8'hCC,
  parameter logic [BYTE_W-1:0] WRITE_CODE = 8'h55
) (
  input  step_e             step,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wbyte,
  output logic              req,
  output eng_op_e           op,
  output logic [BYTE_W-1:0] wdata
);
  always_comb begin
    req   = 1'b1;
    op    = ENG_WRITE;
    wdata = '0;
    unique case (step)
      ST_RST_OPEN, ST_RST_CLOSE: op = ENG_RESET;
      ST_SKIP:     wdata = SKIP_CODE;
      ST_CMD:      wdata = WRITE_CODE;
      ST_ADR_LO:   wdata = addr[BYTE_W-1:0];
      ST_ADR_HI:   wdata = addr[ADDR_W-1:BYTE_W];
      ST_PUT_DATA: wdata = wbyte;
      ST_CRC_LO, ST_CRC_HI, ST_ECHO: op = ENG_READ;
      default: begin
        req = 1'b0;
        op  = ENG_RESET;
      end
    endcase
  end
endmodule

// File: rtl/owseq_rb_cap.sv
module owseq_rb_cap
  import owseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  step_e             step,
  input  logic              take_data,
  input  logic [BYTE_W-1:0] din_data,
  input  logic              eng_ack,
  input  logic [BYTE_W-1:0] eng_rdata,
  input  logic [ADDR_W-1:0] addr,
  output logic [BYTE_W-1:0] wbyte,
  output logic              echo_bad,
  output rb_rec_t           rec
);
  logic [BYTE_W-1:0] wbyte_q;
  logic [BYTE_W-1:0] crc_lo_q;
  rb_rec_t           rec_q;

  assign echo_bad = (eng_rdata != wbyte_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbyte_q  <= '0;
      crc_lo_q <= '0;
      rec_q    <= '0;
    end else begin
      if (take_data) wbyte_q <= din_data;
      if (eng_ack) begin
        unique case (step)
          ST_CRC_LO: crc_lo_q <= eng_rdata;
          ST_CRC_HI: rec_q.crc <= {eng_rdata, crc_lo_q};
          ST_ECHO: begin
            rec_q.addr <= addr;
            rec_q.echo <= eng_rdata;
            rec_q.bad  <= echo_bad;
          end
          default: ;
        endcase
      end
    end
  end

  assign wbyte = wbyte_q;
  assign rec   = rec_q;
endmodule

// File: rtl/owseq_write_txn.sv
module owseq_write_txn
  import owseq_pkg::*;
#(
  parameter int                CNT_W      = 8,
  parameter logic [BYTE_W-1:0] SKIP_CODE  = 8'hCC,
  parameter logic [BYTE_W-1:0] WRITE_CODE = 8'h55
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   start_addr,
  input  logic [CNT_W-1:0]    byte_count,
  output logic                busy,
  output logic                done,
  output logic                error,
  output logic                err_nopres,
  input  logic                din_valid,
  output logic                din_ready,
  input  logic [BYTE_W-1:0]   din_data,
  output logic                rb_valid,
  input  logic                rb_ready,
  output logic [REC_W-1:0]    rb_data,
  output logic                eng_req,
  output logic [1:0]          eng_op,
  output logic [BYTE_W-1:0]   eng_wdata,
  input  logic                eng_ack,
  input  logic [BYTE_W-1:0]   eng_rdata,
  input  logic                eng_presence
);
  step_e             step;
  logic              accept, take_data, advance;
  logic              cnt_zero, cnt_last, echo_bad;
  logic [ADDR_W-1:0] cur_addr;
  logic [BYTE_W-1:0] wbyte;
  eng_op_e           op;
  rb_rec_t           rec;

  owseq_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .eng_ack      (eng_ack),
    .eng_presence (eng_presence),
    .din_valid    (din_valid),
    .rb_ready     (rb_ready),
    .cnt_zero     (cnt_zero),
    .cnt_last     (cnt_last),
    .echo_bad     (echo_bad),
    .step         (step),
    .accept       (accept),
    .take_data    (take_data),
    .advance      (advance),
    .busy         (busy),
    .done         (done),
    .din_ready    (din_ready),
    .rb_valid     (rb_valid),
    .error        (error),
    .err_nopres   (err_nopres)
  );

  owseq_cursor #(.CNT_W(CNT_W)) u_cursor (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .load_addr  (start_addr),
    .load_count (byte_count),
    .advance    (advance),
    .addr       (cur_addr),
    .zero       (cnt_zero),
    .last       (cnt_last)
  );

  owseq_op_sel #(.SKIP_CODE(SKIP_CODE), .WRITE_CODE(WRITE_CODE)) u_op_sel (
    .step  (step),
    .addr  (cur_addr),
    .wbyte (wbyte),
    .req   (eng_req),
    .op    (op),
    .wdata (eng_wdata)
  );

  owseq_rb_cap u_rb_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .take_data (take_data),
    .din_data  (din_data),
    .eng_ack   (eng_ack),
    .eng_rdata (eng_rdata),
    .addr      (cur_addr),
    .wbyte     (wbyte),
    .echo_bad  (echo_bad),
    .rec       (rec)
  );

  assign eng_op  = op;
  assign rb_data = rec;
endmodule

// File: rtl/owseq_write_txn_chk.sv
module owseq_write_txn_chk
  import owseq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              err_nopres,
  input logic              din_ready,
  input logic              rb_valid,
  input logic              rb_ready,
  input logic [REC_W-1:0]  rb_data,
  input logic              eng_req,
  input logic [1:0]        eng_op,
  input logic [BYTE_W-1:0] eng_wdata,
  input logic              eng_ack,
  input logic              eng_presence
);
  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && !eng_ack |=> eng_req && $stable(eng_op) && $stable(eng_wdata));

  a_r11_rb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid && !rb_ready |=> rb_valid && $stable(rb_data));

  a_r11_no_bus_while_out: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |-> !eng_req);

  a_r10_no_bus_while_in: assert property (@(posedge clk) disable iff (!rst_n)
    din_ready |-> !eng_req);

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r12_nopres_implies_error: assert property (@(posedge clk) disable iff (!rst_n)
    err_nopres |-> error);

  a_r9_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  // covers R6 (opening reset) and R7 (closing reset)
  a_r6_presence_flag: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_op == 2'd0 && eng_ack && !eng_presence |=> error && err_nopres);

  a_r5_bad_sets_error: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid && rb_data[0] |-> error);
endmodule

bind owseq_write_txn owseq_write_txn_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .error        (error),
  .err_nopres   (err_nopres),
  .din_ready    (din_ready),
  .rb_valid     (rb_valid),
  .rb_ready     (rb_ready),
  .rb_data      (rb_data),
  .eng_req      (eng_req),
  .eng_op       (eng_op),
  .eng_wdata    (eng_wdata),
  .eng_ack      (eng_ack),
  .eng_presence (eng_presence)
);

// File: tb/owseq_write_txn_bench.sv
`timescale 1ns/1ps
module owseq_write_txn_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] start_addr = '0;
  logic [7:0]  byte_count = '0;
  logic        busy, done, error, err_nopres;
  logic        din_valid = 1'b0;
  logic        din_ready;
  logic [7:0]  din_data = '0;
  logic        rb_valid;
  logic        rb_ready = 1'b0;
  logic [40:0] rb_data;
  logic        eng_req;
  logic [1:0]  eng_op;
  logic [7:0]  eng_wdata;
  logic        eng_ack = 1'b0;
  logic [7:0]  eng_rdata = '0;
  logic        eng_presence = 1'b0;

  always #4 clk = ~clk;

  owseq_write_txn u_owseq_write_txn (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .busy(busy), .done(done), .error(error),
    .err_nopres(err_nopres), .din_valid(din_valid), .din_ready(din_ready),
    .din_data(din_data), .rb_valid(rb_valid), .rb_ready(rb_ready),
    .rb_data(rb_data), .eng_req(eng_req), .eng_op(eng_op),
    .eng_wdata(eng_wdata), .eng_ack(eng_ack), .eng_rdata(eng_rdata),
    .eng_presence(eng_presence)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- engine model ----------------
  bit        e_en = 0;
  int        e_lat = 1;
  bit        pres_open = 1, pres_close = 1;
  int        corrupt_at = -1;
  int        nlog = 0, rst_seen = 0, rd_seen = 0, hs_bad = 0;
  logic [1:0] op_log [0:79];
  logic [7:0] dat_log[0:79];
  logic [7:0] last_w = '0;

  initial begin
    forever begin
      @(negedge clk);
      if (!e_en) begin
        nlog = 0; rst_seen = 0; rd_seen = 0; hs_bad = 0;
      end else if (eng_req && !eng_ack) begin
        logic [1:0] cop;
        logic [7:0] cdat;
        cop = eng_op; cdat = eng_wdata;
        if (nlog < 80) begin op_log[nlog] = cop; dat_log[nlog] = cdat; end
        nlog++;
        repeat (e_lat) begin
          @(negedge clk);
          if (eng_op != cop || eng_wdata != cdat || !eng_req) hs_bad++;
        end
        if (cop == 2'd0) begin
          eng_presence = (rst_seen == 0) ? pres_open : pres_close;
          rst_seen++;
        end else if (cop == 2'd1) begin
          last_w = cdat;
        end else begin
          int k, bi;
          k = rd_seen % 3; bi = rd_seen / 3;
          if (k == 0) eng_rdata = 8'h30 + 8'(bi);
          else if (k == 1) eng_rdata = 8'hC0 + 8'(bi);
          else eng_rdata = last_w ^ ((bi == corrupt_at) ? 8'h5A : 8'h00);
          rd_seen++;
        end
        eng_ack = 1'b1;
        @(negedge clk);
        eng_ack = 1'b0;
        eng_presence = 1'b0;
      end
    end
  end

  // ---------------- data producer ----------------
  bit         p_en = 0, p_gap = 0, p_pend = 0;
  int         p_n = 0, p_idx = 0;
  logic [7:0] src [0:15];

  initial begin
    forever begin
      @(negedge clk);
      if (!p_en) begin
        p_idx = 0; p_pend = 0; din_valid = 1'b0;
      end else begin
        if (p_pend) begin p_idx++; din_valid = 1'b0; end
        if (!din_valid)
          din_valid = (p_idx < p_n) && (!p_gap || (cyc % 3 == 0));
        din_data = (p_idx < 16) ? src[p_idx] : 8'h00;
        p_pend = din_valid && din_ready;
      end
    end
  end

  // ---------------- record consumer ----------------
  bit          c_en = 0, c_stall = 0;
  int          rcnt = 0;
  logic [40:0] recs [0:15];

  initial begin
    forever begin
      @(negedge clk);
      if (!c_en) begin
        rcnt = 0; rb_ready = 1'b0;
      end else begin
        rb_ready = !c_stall || (cyc % 4 == 0);
        if (rb_valid && rb_ready) begin
          if (rcnt < 16) recs[rcnt] = rb_data;
          rcnt++;
        end
      end
    end
  end

  // ---------------- runner ----------------
  int  ndone;
  bit  r_err, r_nopres;

  task automatic run_txn(input logic [15:0] a, input int n, input bit poke);
    bit got;
    e_en = 0; p_en = 0; c_en = 0;
    repeat (2) @(negedge clk);
    p_n = n;
    e_en = 1; p_en = 1; c_en = 1;
    @(negedge clk);
    start = 1'b1; start_addr = a; byte_count = 8'(n);
    @(negedge clk);
    start = 1'b0; start_addr = 16'hBEEF; byte_count = 8'd3;
    chk(busy && !error && !err_nopres, "R12", "flags cleared after start",
        {busy, error, err_nopres}, 3'b100);
    got = 0; ndone = 0;
    for (int i = 0; i < 5000 && !got; i++) begin
      if (poke && i == 20) start = 1'b1;
      else start = 1'b0;
      if (done) begin got = 1; ndone++; r_err = error; r_nopres = err_nopres; end
      else @(negedge clk);
    end
    start = 1'b0;
    chk(got, "R12", "done seen", got, 1);
    @(negedge clk);
    chk(!done && !busy, "R12", "done one cycle", {done, busy}, 0);
    repeat (20) begin
      @(negedge clk);
      if (done) ndone++;
    end
    chk(ndone == 1, "R12", "single done", ndone, 1);
    chk(error == r_err && err_nopres == r_nopres, "R12", "flags hold",
        {error, err_nopres}, {r_err, r_nopres});
    chk(hs_bad == 0, "R13", "request stable until ack", hs_bad, 0);
  endtask

  task automatic check_ops(input string req, input logic [15:0] a, input int n);
    int bad, exp_n, j;
    bad = 0; exp_n = 6 + 4 * n;
    j = 0;
    if (op_log[0] != 2'd0) bad++;
    if (op_log[1] != 2'd1 || dat_log[1] != 8'hCC) bad++;
    if (op_log[2] != 2'd1 || dat_log[2] != 8'h55) bad++;
    if (op_log[3] != 2'd1 || dat_log[3] != a[7:0]) bad++;
    if (op_log[4] != 2'd1 || dat_log[4] != a[15:8]) bad++;
    for (int i = 0; i < n; i++) begin
      j = 5 + 4 * i;
      if (op_log[j] != 2'd1 || dat_log[j] != src[i]) bad++;
      for (int k = 1; k < 4; k++) if (op_log[j + k] != 2'd2) bad++;
    end
    if (op_log[exp_n - 1] != 2'd0) bad++;
    chk(nlog == exp_n, req, "operation count", nlog, exp_n);
    chk(bad == 0, req, "operation sequence mismatches", bad, 0);
  endtask

  task automatic check_recs(input string req, input logic [15:0] a, input int n);
    int bad;
    logic [40:0] exp;
    bad = 0;
    chk(rcnt == n, req, "record count", rcnt, n);
    for (int i = 0; i < n && i < 16; i++) begin
      exp = {a + 16'(i), 8'hC0 + 8'(i), 8'h30 + 8'(i),
             src[i] ^ ((i == corrupt_at) ? 8'h5A : 8'h00), (i == corrupt_at)};
      if (recs[i] !== exp) begin
        bad++;
        $display("FAIL %s record %0d: actual %0h expected %0h", req, i, recs[i], exp);
      end
    end
    chk(bad == 0, req, "record contents", bad, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk(!busy && !done && !error && !err_nopres, "R1", "status idle",
        {busy, done, error, err_nopres}, 0);
    chk(!eng_req && !din_ready && !rb_valid, "R1", "handshakes idle",
        {eng_req, din_ready, rb_valid}, 0);
  endtask

  task automatic t_single;
    src[0] = 8'h80;
    e_lat = 1; corrupt_at = -1; pres_open = 1; pres_close = 1;
    p_gap = 0; c_stall = 0;
    run_txn(16'h0008, 1, 0);
    check_ops("R2", 16'h0008, 1);
    check_recs("R4", 16'h0008, 1);
    chk(!r_err && !r_nopres, "R12", "clean flags", {r_err, r_nopres}, 0);
  endtask

  task automatic t_burst_backpressure;
    for (int i = 0; i < 5; i++) src[i] = 8'h11 * 8'(i + 1);
    e_lat = 3; corrupt_at = -1; p_gap = 1; c_stall = 1;
    run_txn(16'h12FE, 5, 0);
    check_ops("R2", 16'h12FE, 5);
    check_recs("R3", 16'h12FE, 5);
    chk(p_idx == 5, "R10", "bytes consumed", p_idx, 5);
    chk(!r_err, "R11", "no error under stalls", r_err, 0);
  endtask

  task automatic t_wrap;
    src[0] = 8'hA5; src[1] = 8'h5A;
    e_lat = 1; corrupt_at = -1; p_gap = 0; c_stall = 0;
    run_txn(16'hFFFF, 2, 0);
    check_recs("R3", 16'hFFFF, 2);
  endtask

  task automatic t_mismatch;
    for (int i = 0; i < 4; i++) src[i] = 8'h40 + 8'(i);
    e_lat = 2; corrupt_at = 1; p_gap = 0; c_stall = 1;
    run_txn(16'h0200, 4, 0);
    check_ops("R5", 16'h0200, 4);
    check_recs("R5", 16'h0200, 4);
    chk(r_err && !r_nopres, "R5", "mismatch flags", {r_err, r_nopres}, 2'b10);
    corrupt_at = -1;
  endtask

  task automatic t_clean_after_error;
    src[0] = 8'h3C;
    e_lat = 1; p_gap = 0; c_stall = 0;
    run_txn(16'h0300, 1, 0);
    chk(!r_err && !r_nopres, "R12", "error cleared by new start", {r_err, r_nopres}, 0);
  endtask

  task automatic t_no_presence_open;
    src[0] = 8'h99;
    pres_open = 0; pres_close = 1;
    run_txn(16'h0400, 3, 0);
    chk(nlog == 1 && op_log[0] == 2'd0, "R6", "only opening reset", nlog, 1);
    chk(p_idx == 0 && rcnt == 0, "R6", "no data or records", {p_idx[7:0], rcnt[7:0]}, 0);
    chk(r_err && r_nopres, "R6", "abort flags", {r_err, r_nopres}, 2'b11);
    pres_open = 1;
  endtask

  task automatic t_no_presence_close;
    src[0] = 8'h12; src[1] = 8'h34;
    pres_close = 0;
    run_txn(16'h0500, 2, 0);
    check_ops("R7", 16'h0500, 2);
    check_recs("R7", 16'h0500, 2);
    chk(r_err && r_nopres, "R7", "closing presence flags", {r_err, r_nopres}, 2'b11);
    pres_close = 1;
  endtask

  task automatic t_zero_count;
    run_txn(16'h0607, 0, 0);
    check_ops("R8", 16'h0607, 0);
    chk(p_idx == 0 && rcnt == 0, "R8", "no data or records", {p_idx[7:0], rcnt[7:0]}, 0);
  endtask

  task automatic t_start_while_busy;
    for (int i = 0; i < 3; i++) src[i] = 8'hE0 + 8'(i);
    e_lat = 2;
    run_txn(16'h0700, 3, 1);
    check_ops("R9", 16'h0700, 3);
    check_recs("R9", 16'h0700, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_single;
    t_burst_backpressure;
    t_wrap;
    t_mismatch;
    t_clean_after_error;
    t_no_presence_open;
    t_no_presence_close;
    t_zero_count;
    t_start_while_busy;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule